// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block turns a single request from a processor core into a timed external memory cycle. A request is one of three kinds: a code fetch, a data read or a data write. It carries an address and, for writes, a byte of write data. The sequencer latches the request and drives the address bus. It then lowers exactly one active-low strobe at a fixed clock offset and holds it low for a fixed number of clocks. During a read it samples the incoming data bus on a fixed clock. During a write it drives the outgoing data bus with an enable.

Every offset is counted in input clock periods from the first slot of the cycle. A code fetch takes six slots. A data read or write takes twelve slots, S1 to S12. Each cycle ends with a one-clock done pulse. The core waits for the ready output before it issues the next request.

Top module: `ext_bus_seq`

## Requirements
- R1: After synchronous reset, psen_n, rd_n and wr_n are high, data_oe and done are low, ready is high, rdata is zero and addr_o is zero (the default setting drives a zero address while idle).
- R2: A request is taken only on a clock edge where req_valid is high and ready is high. A request presented while a cycle is running has no effect: the address, strobes and data bus of the running cycle are unchanged, and no new cycle follows.
- R3: A code fetch (req_kind 2'b00) holds addr_o at the request address for slots S1 to S6. psen_n is low in slots S3 and S4 only, which places its fall two clocks after the address becomes valid.
- R4: A code fetch samples data_in on the clock edge that ends S4, two clocks after psen_n falls, and presents the value on rdata from S5 onward. The fetch lasts six slots.
- R5: A data read (req_kind 2'b01) holds addr_o for S1 to S12. rd_n is low for exactly six clocks, S5 to S10, which places its fall four clocks after the address becomes valid.
- R6: A data read samples data_in on the edge that ends S10, the last clock of the rd_n pulse. rdata keeps the captured value until the next fetch or read; a write leaves it unchanged.
- R7: A data write (req_kind 2'b10) holds addr_o for S1 to S12. wr_n is low for exactly six clocks, S5 to S10.
- R8: During a write, data_oe is high and data_o equals the write data in slots S4 to S11, one clock before wr_n falls and one clock after it rises. data_oe is low in every other slot and throughout fetch and read cycles.
- R9: done is high for exactly one clock, in the last slot of a cycle (S6 for a fetch, S12 for a read or write). ready is low from S1 through the last slot and high again in the clock after it.
- R10: The reserved kind 2'b11 is never accepted. ready stays high, all strobes stay high and addr_o stays idle.
- R11: At most one of psen_n, rd_n and wr_n is low at any time, and a strobe is low only while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per period |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe from the core |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | High when idle and able to take a request |
| done | output | 1 | One-clock pulse in the last slot |
| rdata | output | DATA_W | Last captured fetch or read data |
| addr_o | output | ADDR_W | External address bus |
| data_o | output | DATA_W | Outgoing data bus value |
| data_oe | output | 1 | Output enable for the data bus |
| data_in | input | DATA_W | Incoming data bus value |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach is a request that arrives in the middle of a running cycle. It has to collide with the latched address and strobe windows, and it must leave no trace once the running cycle ends. The bench reaches it by raising req_valid with a write of a different address and data in S3 of a read cycle and keeping it raised until S8. It then checks every slot of the read against the expected values, and afterwards checks that the sequencer stays idle with all strobes high. To prove that the sampling clock is exact, the bench drives a different data_in value in every slot. The value that appears on rdata then shows which edge did the capture.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [1:0] {
      EBS_FETCH = 2'b00,
      EBS_READ  = 2'b01,
      EBS_WRITE = 2'b10,
      EBS_RSVD  = 2'b11
   } ebs_kind_e;

endpackage

// File: rtl/ebs_window.sv
// Decodes an inclusive slot range [LO, HI] gated by an enable.
module ebs_window #(
   parameter int SW = 4,
   parameter int LO = 0,
   parameter int HI = 0
) (
   input  logic          en,
   input  logic [SW-1:0] slot,
   output logic          hit
);
   localparam logic [SW-1:0] LO_V = SW'(LO);
   localparam logic [SW-1:0] HI_V = SW'(HI);

   initial begin : window_param_chk
      assert (LO <= HI && HI < (1 << SW))
         else $error("ebs_window: bad range");
   end

   generate
      if (LO == 0) begin : g_from_zero
         assign hit = en && (slot <= HI_V);
      end else if (LO == HI) begin : g_single
         assign hit = en && (slot == LO_V);
      end else begin : g_range
         assign hit = en && (slot >= LO_V) && (slot <= HI_V);
      end
   endgenerate
endmodule

// File: rtl/ebs_sequencer.sv
// Request acceptance, latching and slot counting.
module ebs_sequencer
   import ebs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SW          = 4,
   parameter int FETCH_SLOTS = 6,
   parameter int DATA_SLOTS  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              last,
   output logic [SW-1:0]     slot,
   output ebs_kind_e         kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);
   localparam logic [SW-1:0] F_LAST = SW'(FETCH_SLOTS - 1);
   localparam logic [SW-1:0] D_LAST = SW'(DATA_SLOTS - 1);

   logic accept;

   assign accept = req_valid && !busy && (ebs_kind_e'(req_kind) != EBS_RSVD);
   assign last   = busy && (slot == ((kind_q == EBS_FETCH) ? F_LAST : D_LAST));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         slot    <= '0;
         kind_q  <= EBS_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (!busy) begin
         if (accept) begin
            busy    <= 1'b1;
            slot    <= '0;
            kind_q  <= ebs_kind_e'(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end else if (last) begin
         busy <= 1'b0;
         slot <= '0;
      end else begin
         slot <= slot + 1'b1;
      end
   end

   // R2
   hold_off_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> (busy && $stable(addr_q) && $stable(kind_q) && $stable(wdata_q)));

   // R9
   done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
      last |=> !busy);

   // R10
   rsvd_reject_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && req_valid && req_kind == 2'b11) |=> !busy);
endmodule

// File: rtl/ebs_strobes.sv
// Slot-window decode of strobes, bus enable and capture points.
module ebs_strobes
   import ebs_pkg::*;
#(
   parameter int SW          = 4,
   parameter int FETCH_SETUP = 2,
   parameter int FETCH_PULSE = 2,
   parameter int DATA_SETUP  = 4,
   parameter int DATA_PULSE  = 6,
   parameter int WR_LEAD     = 1,
   parameter int WR_HOLD     = 1
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      busy,
   input  logic [SW-1:0] slot,
   input  ebs_kind_e kind_q,
   output logic      psen_n,
   output logic      rd_n,
   output logic      wr_n,
   output logic      data_oe,
   output logic      cap_en
);
   localparam int P_LO  = FETCH_SETUP;
   localparam int P_HI  = FETCH_SETUP + FETCH_PULSE - 1;
   localparam int D_LO  = DATA_SETUP;
   localparam int D_HI  = DATA_SETUP + DATA_PULSE - 1;
   localparam int OE_LO = D_LO - WR_LEAD;
   localparam int OE_HI = D_HI + WR_HOLD;

   logic is_f, is_r, is_w;
   logic psen_hit, rd_hit, wr_hit, oe_hit, fcap_hit, rcap_hit;

   assign is_f = busy && (kind_q == EBS_FETCH);
   assign is_r = busy && (kind_q == EBS_READ);
   assign is_w = busy && (kind_q == EBS_WRITE);

   ebs_window #(.SW(SW), .LO(P_LO),  .HI(P_HI))  u_psen (.en(is_f), .slot(slot), .hit(psen_hit));
   ebs_window #(.SW(SW), .LO(D_LO),  .HI(D_HI))  u_rd   (.en(is_r), .slot(slot), .hit(rd_hit));
   ebs_window #(.SW(SW), .LO(D_LO),  .HI(D_HI))  u_wr   (.en(is_w), .slot(slot), .hit(wr_hit));
   ebs_window #(.SW(SW), .LO(OE_LO), .HI(OE_HI)) u_oe   (.en(is_w), .slot(slot), .hit(oe_hit));
   ebs_window #(.SW(SW), .LO(P_HI),  .HI(P_HI))  u_fcap (.en(is_f), .slot(slot), .hit(fcap_hit));
   ebs_window #(.SW(SW), .LO(D_HI),  .HI(D_HI))  u_rcap (.en(is_r), .slot(slot), .hit(rcap_hit));

   assign psen_n  = !psen_hit;
   assign rd_n    = !rd_hit;
   assign wr_n    = !wr_hit;
   assign data_oe = oe_hit;
   assign cap_en  = fcap_hit || rcap_hit;

   logic [SW:0] rd_run;
   logic [SW:0] wr_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_run <= '0;
         wr_run <= '0;
      end else begin
         rd_run <= rd_n ? '0 : rd_run + 1'b1;
         wr_run <= wr_n ? '0 : wr_run + 1'b1;
      end
   end

   // R11
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({!psen_n, !rd_n, !wr_n}) <= 1);

   // R8
   no_drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !psen_n) |-> !data_oe);

   // R8
   wr_lead_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_n) |-> $past(data_oe));

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_n) |-> data_oe);

   // R5
   rd_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_n) |-> (rd_run == (SW+1)'(DATA_PULSE)));

   // R7
   wr_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_n) |-> (wr_run == (SW+1)'(DATA_PULSE)));
endmodule

// File: rtl/ebs_capture.sv
// Read data register loaded on the capture slot.
module ebs_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk) begin
      if (rst)         rdata <= '0;
      else if (cap_en) rdata <= data_in;
   end

   // R6
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(cap_en) |-> $stable(rdata));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int FETCH_SETUP    = 2,
   parameter int FETCH_PULSE    = 2,
   parameter int FETCH_SLOTS    = 6,
   parameter int DATA_SETUP     = 4,
   parameter int DATA_PULSE     = 6,
   parameter int DATA_SLOTS     = 12,
   parameter int WR_LEAD        = 1,
   parameter int WR_HOLD        = 1,
   parameter bit ADDR_HOLD_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   input  logic [DATA_W-1:0] data_in,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n
);
   localparam int MAX_SLOTS = (DATA_SLOTS > FETCH_SLOTS) ? DATA_SLOTS : FETCH_SLOTS;
   localparam int SW        = (MAX_SLOTS > 2) ? $clog2(MAX_SLOTS) : 1;

   initial begin : top_param_chk
      assert (FETCH_SETUP >= 1 && FETCH_PULSE >= 1 && FETCH_SETUP + FETCH_PULSE <= FETCH_SLOTS)
         else $error("ext_bus_seq: fetch timing does not fit");
      assert (WR_LEAD >= 1 && WR_LEAD <= DATA_SETUP && DATA_PULSE >= 1)
         else $error("ext_bus_seq: write lead does not fit");
      assert (DATA_SETUP + DATA_PULSE + WR_HOLD <= DATA_SLOTS)
         else $error("ext_bus_seq: data timing does not fit");
   end

   logic              busy, last, cap_en;
   logic [SW-1:0]     slot;
   ebs_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   ebs_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW(SW),
      .FETCH_SLOTS(FETCH_SLOTS), .DATA_SLOTS(DATA_SLOTS)
   ) u_seq (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .last(last),
      .slot(slot), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q)
   );

   ebs_strobes #(
      .SW(SW), .FETCH_SETUP(FETCH_SETUP), .FETCH_PULSE(FETCH_PULSE),
      .DATA_SETUP(DATA_SETUP), .DATA_PULSE(DATA_PULSE),
      .WR_LEAD(WR_LEAD), .WR_HOLD(WR_HOLD)
   ) u_stb (
      .clk(clk), .rst(rst), .busy(busy), .slot(slot), .kind_q(kind_q),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .data_oe(data_oe), .cap_en(cap_en)
   );

   ebs_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst(rst), .cap_en(cap_en), .data_in(data_in), .rdata(rdata)
   );

   assign ready  = !busy;
   assign done   = last;
   assign data_o = data_oe ? wdata_q : '0;

   generate
      if (ADDR_HOLD_IDLE) begin : g_addr_hold
         assign addr_o = addr_q;
      end else begin : g_addr_zero
         assign addr_o = busy ? addr_q : '0;
      end
   endgenerate

   // R11
   strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (!psen_n || !rd_n || !wr_n) |-> !ready);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && ready));
endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ready, done, data_oe, psen_n, rd_n, wr_n;
   logic [7:0]  rdata, data_o;
   logic [15:0] addr_o;
   logic [7:0]  data_in = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] exp_rdata = '0;

   always #10 clk = !clk;

   ext_bus_seq u_ext_bus_seq (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
      .rdata(rdata), .addr_o(addr_o), .data_o(data_o), .data_oe(data_oe),
      .data_in(data_in), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(ready == 1'b1, req, ready, 1);
      chk(done == 1'b0, req, done, 0);
      chk({psen_n, rd_n, wr_n} == 3'b111, req, {psen_n, rd_n, wr_n}, 7);
      chk(data_oe == 1'b0, req, data_oe, 0);
      chk(addr_o == 16'h0, req, addr_o, 0);
   endtask

   // R1
   task automatic t_reset();
      chk_idle("R1 idle after reset");
      chk(rdata == 8'h00, "R1 rdata", rdata, 0);
   endtask

   // Runs one cycle; R2 intrusion optionally requested in slots 3..8.
   task automatic t_cycle(input logic [1:0] k, input logic [15:0] a,
                          input logic [7:0] w, input logic [7:0] pat, input bit intrude);
      int n = (k == 2'b00) ? 6 : 12;
      int cs = (k == 2'b00) ? 4 : 10;
      string tag = (k == 2'b00) ? "R3" : (k == 2'b01) ? "R5" : "R7";
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w; data_in = pat;
      @(negedge clk);
      req_valid = 1'b0;
      for (int s = 1; s <= n; s++) begin
         data_in = pat ^ 8'(s);
         if (intrude && s == 3) begin
            req_valid = 1'b1; req_kind = 2'b10; req_addr = ~a; req_wdata = ~w;
         end
         if (intrude && s == 8) req_valid = 1'b0;
         chk(addr_o == a, intrude ? "R2 addr held" : tag, addr_o, a);
         chk(psen_n == !(k == 2'b00 && (s == 3 || s == 4)), "R3 psen_n", psen_n,
             !(k == 2'b00 && (s == 3 || s == 4)));
         chk(rd_n == !(k == 2'b01 && s >= 5 && s <= 10), "R5 rd_n", rd_n,
             !(k == 2'b01 && s >= 5 && s <= 10));
         chk(wr_n == !(k == 2'b10 && s >= 5 && s <= 10), intrude ? "R2 wr_n" : "R7 wr_n",
             wr_n, !(k == 2'b10 && s >= 5 && s <= 10));
         chk(data_oe == (k == 2'b10 && s >= 4 && s <= 11), "R8 data_oe", data_oe,
             (k == 2'b10 && s >= 4 && s <= 11));
         if (k == 2'b10 && s >= 4 && s <= 11)
            chk(data_o == w, "R8 data_o", data_o, w);
         chk(done == (s == n), "R9 done", done, (s == n));
         chk(ready == 1'b0, "R9 ready low", ready, 0);
         if (k != 2'b10 && s == cs + 1)
            chk(rdata == (pat ^ 8'(cs)), (k == 2'b00) ? "R4 fetch capture" : "R6 read capture",
                rdata, pat ^ 8'(cs));
         @(negedge clk);
      end
      if (k != 2'b10) exp_rdata = pat ^ 8'(cs);
      chk(rdata == exp_rdata, (k == 2'b10) ? "R6 rdata kept over write" : "R6 rdata held",
          rdata, exp_rdata);
      chk_idle("R9 idle after done");
      if (intrude) begin
         repeat (3) begin
            @(negedge clk);
            chk_idle("R2 no follow-on cycle");
         end
      end
   endtask

   // R10
   task automatic t_reserved();
      req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h5A5A;
      repeat (4) begin
         @(negedge clk);
         chk_idle("R10 reserved kind");
      end
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   // R11 checked every clock
   always @(negedge clk) begin
      if (!rst && !finished) begin
         chk(((!psen_n) + (!rd_n) + (!wr_n)) <= 1, "R11 one strobe", {psen_n, rd_n, wr_n}, 0);
         if (!psen_n || !rd_n || !wr_n) chk(!ready, "R11 strobe while busy", ready, 0);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_cycle(2'b00, 16'h1234, 8'h00, 8'hA0, 1'b0);
      t_cycle(2'b00, 16'hFFFE, 8'h00, 8'h3C, 1'b0);
      t_cycle(2'b01, 16'h8001, 8'h00, 8'h50, 1'b0);
      t_cycle(2'b10, 16'h00FF, 8'hC3, 8'h11, 1'b0);
      t_cycle(2'b10, 16'h7F00, 8'h5A, 8'h22, 1'b0);
      t_cycle(2'b01, 16'h4321, 8'h00, 8'h90, 1'b1);
      t_reserved();
      t_cycle(2'b01, 16'hBEEF, 8'h00, 8'h0F, 1'b0);
      t_cycle(2'b00, 16'h0001, 8'h00, 8'hE7, 1'b0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule